// File: doc/BRIEF.md
# Exception Entry and Vector Controller

This block turns one exception request from a 32-bit processor pipeline into the complete set of architectural updates needed to enter the handler. From the exception kind, the faulting program counter, the delay-slot flag, the current status bits, the current cause register and the exception base register, it works out the handler address. It also produces the return address to save, the new cause register image and the new status bits, and it says which return register (normal or error) must be written.

Requests arrive on a valid/ready channel. Each accepted request produces one registered response, marked by `resp_valid` on the following cycle. The response stays on the outputs until the consumer raises `resp_ready`. The request side is ready whenever the response register is empty or is being drained in the same cycle (`req_ready = !resp_valid || resp_ready`), so back-pressure from the consumer stalls the producer with no loss and no reordering. The block holds no processor state of its own. The caller commits the returned values.

Top module: `exc_entry_ctrl`

## Requirements
- R1: A request is taken when `req_valid && req_ready`. Its result appears with `resp_valid` high on the next clock edge. `req_ready` equals `!resp_valid || resp_ready`. While `resp_valid && !resp_ready`, every response output holds its value.
- R2: For general exceptions, `req_kind` equals the cause code: interrupt 0, TLB modify 1, TLB load 2, TLB store 3, address error load 4, address error store 5, instruction bus error 6, data bus error 7, syscall 8, breakpoint 9, reserved instruction 10, coprocessor unusable 11, overflow 12, trap 13, floating point 15, machine check 24, cache error 30. The code is written into `resp_cause[6:2]`. All other cause bits pass through from `cause_in`, except BD (bit 31) and CE (bits 29:28) as R3/R4/R8 state.
- R3: Status vector bits are: [0] EXL, [1] ERL, [2] BEV, [3] SR, [4] NMI. For a general exception with EXL clear, `resp_epc_we` is 1. The saved PC is PC−4 with BD=1 when `req_in_delay` is set, and PC with BD=0 otherwise. EXL is set in `resp_status`.
- R4: For a general exception with EXL set, `resp_epc_we` is 0, BD keeps its `cause_in` value, and `resp_status` equals `status_in`.
- R5: The general vector base is 0xBFC00200 when BEV is set. Otherwise it is `ebase` with bits 9:0 cleared.
- R6: The vector offset is 0x180 by default. An interrupt uses 0x200 when `cause_in[23]` (vectored-interrupt bit) is set.
- R7: TLB load or TLB store with `req_refill` set and EXL clear uses offset 0x000. With EXL set, it uses 0x180.
- R8: Coprocessor unusable writes `req_cop` into `resp_cause[29:28]`.
- R9: Cache error jumps to 0xBFC00100 when BEV is set, and otherwise to (`ebase` & ~0x3FF) + 0x20000100.
- R10: Kind 20 (NMI) and kind 21 (soft reset) follow the R3 delay-slot rule to give the return PC, and set `resp_errepc_we`, not `resp_epc_we`. They set ERL and BEV, plus NMI for kind 20 or SR for kind 21. They jump to 0xBFC00000 and leave `resp_cause` equal to `cause_in`.
- R11: Any other kind sets `resp_err`. Both write enables are 0, `resp_cause` equals `cause_in`, `resp_status` equals `status_in`, and `resp_pc` equals `req_pc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle if valid |
| req_kind | input | 5 | Exception kind |
| req_pc | input | 32 | PC of the faulting instruction |
| req_in_delay | input | 1 | Instruction sits in a branch delay slot |
| req_refill | input | 1 | TLB miss with no matching entry |
| req_cop | input | 2 | Coprocessor number for unusable fault |
| status_in | input | 5 | Current status bits {NMI,SR,BEV,ERL,EXL} |
| cause_in | input | 32 | Current cause register |
| ebase | input | 32 | Exception base register |
| resp_valid | output | 1 | Response present |
| resp_ready | input | 1 | Consumer takes the response |
| resp_err | output | 1 | Unsupported kind, no state change |
| resp_pc | output | 32 | Handler address |
| resp_ret_pc | output | 32 | Return address to save |
| resp_epc_we | output | 1 | Write return address to EPC |
| resp_errepc_we | output | 1 | Write return address to ErrorEPC |
| resp_cause | output | 32 | New cause register |
| resp_status | output | 5 | New status bits |

## Verification
General exceptions are driven with EXL clear and set, inside and outside a delay slot. This separates the EPC/BD update from the preserve path. BEV, a base register with dirty low bits and the vectored-interrupt bit are toggled one at a time, so the wrong base or offset shows up in the handler address. TLB refill with and without EXL, cache error under both BEV values, and the two error-level entries probe the special vectors. An unsupported kind and a stalled consumer show that nothing changes where nothing should.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int XW      = 32;
  localparam int KW      = 5;
  localparam int SW      = 5;
  localparam int CODE_LO = 2;
  localparam int CODE_HI = CODE_LO + KW - 1;
  localparam int CE_LO   = 28;
  localparam int CE_HI   = 29;
  localparam int BD_POS  = 31;
  localparam int IV_POS  = 23;
  localparam int BASE_CLR_BITS = 10;

  localparam int ST_EXL = 0;
  localparam int ST_ERL = 1;
  localparam int ST_BEV = 2;
  localparam int ST_SR  = 3;
  localparam int ST_NMI = 4;

  localparam logic [XW-1:0] BOOT_GEN_BASE = 32'hBFC0_0200;
  localparam logic [XW-1:0] BOOT_ERR_VEC  = 32'hBFC0_0000;
  localparam logic [XW-1:0] BOOT_CACHE    = 32'hBFC0_0100;
  localparam logic [XW-1:0] CACHE_REL_OFS = 32'h2000_0100;
  localparam logic [XW-1:0] OFS_GENERAL   = 32'h0000_0180;
  localparam logic [XW-1:0] OFS_VECT_INT  = 32'h0000_0200;
  localparam logic [XW-1:0] OFS_REFILL    = 32'h0000_0000;

  localparam logic [KW-1:0] K_INT   = 5'd0;
  localparam logic [KW-1:0] K_TLBL  = 5'd2;
  localparam logic [KW-1:0] K_TLBS  = 5'd3;
  localparam logic [KW-1:0] K_CPU   = 5'd11;
  localparam logic [KW-1:0] K_CACHE = 5'd30;
  localparam logic [KW-1:0] K_NMI   = 5'd20;
  localparam logic [KW-1:0] K_SRST  = 5'd21;

  typedef enum logic [1:0] {
    CLS_GENERAL = 2'd0,
    CLS_ERRLVL  = 2'd1,
    CLS_BAD     = 2'd2
  } exc_class_e;

  typedef struct packed {
    exc_class_e   cls;
    logic [KW-1:0] code;
    logic          is_int;
    logic          is_tlb;
    logic          is_cpu;
    logic          is_cache;
    logic          is_nmi;
  } exc_dec_t;
endpackage

// File: rtl/exc_decode.sv
module exc_decode
  import exc_entry_pkg::*;
(
  input  logic [KW-1:0] kind,
  output exc_dec_t      dec
);
  always_comb begin
    dec          = '0;
    dec.cls      = CLS_GENERAL;
    dec.code     = kind;
    dec.is_int   = (kind == K_INT);
    dec.is_tlb   = (kind == K_TLBL) || (kind == K_TLBS);
    dec.is_cpu   = (kind == K_CPU);
    dec.is_cache = (kind == K_CACHE);
    dec.is_nmi   = (kind == K_NMI);
    unique case (kind)
      5'd0, 5'd1, 5'd2, 5'd3, 5'd4, 5'd5, 5'd6, 5'd7,
      5'd8, 5'd9, 5'd10, 5'd11, 5'd12, 5'd13, 5'd15,
      5'd24, 5'd30:     dec.cls = CLS_GENERAL;
      K_NMI, K_SRST:    dec.cls = CLS_ERRLVL;
      default:          dec.cls = CLS_BAD;
    endcase
  end
endmodule

// File: rtl/exc_vector.sv
module exc_vector
  import exc_entry_pkg::*;
(
  input  exc_dec_t      dec,
  input  logic          bev,
  input  logic          exl,
  input  logic          iv,
  input  logic          refill,
  input  logic [XW-1:0] ebase,
  output logic [XW-1:0] vec_pc
);
  logic [XW-1:0] reloc_base;
  logic [XW-1:0] gen_base;
  logic [XW-1:0] offset;

  assign reloc_base = {ebase[XW-1:BASE_CLR_BITS], {BASE_CLR_BITS{1'b0}}};
  assign gen_base   = bev ? BOOT_GEN_BASE : reloc_base;

  always_comb begin
    if (dec.is_tlb && refill && !exl) offset = OFS_REFILL;
    else if (dec.is_int && iv)        offset = OFS_VECT_INT;
    else                              offset = OFS_GENERAL;
  end

  always_comb begin
    if (dec.cls == CLS_ERRLVL)  vec_pc = BOOT_ERR_VEC;
    else if (dec.is_cache)      vec_pc = bev ? BOOT_CACHE : (reloc_base + CACHE_REL_OFS);
    else                        vec_pc = gen_base + offset;
  end

  always_comb begin
    if (dec.cls != CLS_BAD)
      assert (vec_pc[1:0] == 2'b00 || ebase[1:0] != 2'b00)
        else $error("AST_VEC_WORD_ALIGNED"); // R5
  end
endmodule

// File: rtl/exc_retpc.sv
module exc_retpc
  import exc_entry_pkg::*;
(
  input  logic [XW-1:0] pc,
  input  logic          in_delay,
  output logic [XW-1:0] ret_pc,
  output logic          bd
);
  localparam logic [XW-1:0] INSN_BYTES = 32'd4;
  assign ret_pc = in_delay ? (pc - INSN_BYTES) : pc;
  assign bd     = in_delay;
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [4:0]    req_kind,
  input  logic [31:0]   req_pc,
  input  logic          req_in_delay,
  input  logic          req_refill,
  input  logic [1:0]    req_cop,
  input  logic [4:0]    status_in,
  input  logic [31:0]   cause_in,
  input  logic [31:0]   ebase,
  output logic          resp_valid,
  input  logic          resp_ready,
  output logic          resp_err,
  output logic [31:0]   resp_pc,
  output logic [31:0]   resp_ret_pc,
  output logic          resp_epc_we,
  output logic          resp_errepc_we,
  output logic [31:0]   resp_cause,
  output logic [4:0]    resp_status
);
  exc_dec_t      dec;
  logic [XW-1:0] vec_pc;
  logic [XW-1:0] ret_pc;
  logic          bd;

  logic          n_err, n_epc_we, n_errepc_we;
  logic [XW-1:0] n_pc, n_cause;
  logic [SW-1:0] n_status;
  logic          take;

  exc_decode u_dec (.kind(req_kind), .dec(dec));

  exc_vector u_vec (
    .dec(dec), .bev(status_in[ST_BEV]), .exl(status_in[ST_EXL]),
    .iv(cause_in[IV_POS]), .refill(req_refill), .ebase(ebase), .vec_pc(vec_pc)
  );

  exc_retpc u_ret (.pc(req_pc), .in_delay(req_in_delay), .ret_pc(ret_pc), .bd(bd));

  assign req_ready = !resp_valid || resp_ready;
  assign take      = req_valid && req_ready;

  always_comb begin
    n_err       = 1'b0;
    n_epc_we    = 1'b0;
    n_errepc_we = 1'b0;
    n_pc        = vec_pc;
    n_cause     = cause_in;
    n_status    = status_in;
    unique case (dec.cls)
      CLS_GENERAL: begin
        n_cause[CODE_HI:CODE_LO] = dec.code;
        if (dec.is_cpu) n_cause[CE_HI:CE_LO] = req_cop;
        if (!status_in[ST_EXL]) begin
          n_epc_we         = 1'b1;
          n_cause[BD_POS]  = bd;
          n_status[ST_EXL] = 1'b1;
        end
      end
      CLS_ERRLVL: begin
        n_errepc_we      = 1'b1;
        n_status[ST_ERL] = 1'b1;
        n_status[ST_BEV] = 1'b1;
        if (dec.is_nmi) n_status[ST_NMI] = 1'b1;
        else            n_status[ST_SR]  = 1'b1;
      end
      default: begin
        n_err = 1'b1;
        n_pc  = req_pc;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid     <= 1'b0;
      resp_err       <= 1'b0;
      resp_pc        <= '0;
      resp_ret_pc    <= '0;
      resp_epc_we    <= 1'b0;
      resp_errepc_we <= 1'b0;
      resp_cause     <= '0;
      resp_status    <= '0;
    end else if (take) begin
      resp_valid     <= 1'b1;
      resp_err       <= n_err;
      resp_pc        <= n_pc;
      resp_ret_pc    <= ret_pc;
      resp_epc_we    <= n_epc_we;
      resp_errepc_we <= n_errepc_we;
      resp_cause     <= n_cause;
      resp_status    <= n_status;
    end else if (resp_ready) begin
      resp_valid     <= 1'b0;
    end
  end

  AST_ACK_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> resp_valid) else $error("AST_ACK_NEXT_CYCLE"); // R1
  AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_ready) |=> (resp_valid && $stable(resp_pc) && $stable(resp_cause)
                                     && $stable(resp_status))) else $error("AST_HOLD_UNDER_STALL"); // R1
  AST_ONE_RET_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> !(resp_epc_we && resp_errepc_we)) else $error("AST_ONE_RET_TARGET"); // R10
  AST_EPC_SETS_EXL: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_epc_we) |-> resp_status[ST_EXL]) else $error("AST_EPC_SETS_EXL"); // R3
  AST_ERR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_err) |-> (!resp_epc_we && !resp_errepc_we)) else $error("AST_ERR_NO_WRITE"); // R11
  AST_EXL_HELD_NO_EPC: assert property (@(posedge clk) disable iff (!rst_n)
    (take && status_in[ST_EXL]) |=> !resp_epc_we) else $error("AST_EXL_HELD_NO_EPC"); // R4
endmodule

// File: tb/exc_entry_ctrl_tb.sv
module exc_entry_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_in_delay = 1'b0, req_refill = 1'b0, resp_ready = 1'b1;
  logic [4:0] req_kind = '0, status_in = '0;
  logic [1:0] req_cop = '0;
  logic [31:0] req_pc = '0, cause_in = '0, ebase = 32'h8000_0000;
  logic req_ready, resp_valid, resp_err, resp_epc_we, resp_errepc_we;
  logic [31:0] resp_pc, resp_ret_pc, resp_cause;
  logic [4:0] resp_status;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  exc_entry_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_pc(req_pc), .req_in_delay(req_in_delay),
    .req_refill(req_refill), .req_cop(req_cop), .status_in(status_in),
    .cause_in(cause_in), .ebase(ebase), .resp_valid(resp_valid),
    .resp_ready(resp_ready), .resp_err(resp_err), .resp_pc(resp_pc),
    .resp_ret_pc(resp_ret_pc), .resp_epc_we(resp_epc_we),
    .resp_errepc_we(resp_errepc_we), .resp_cause(resp_cause), .resp_status(resp_status)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [4:0] k, input logic [31:0] pc, input logic dly,
                      input logic [4:0] st, input logic [31:0] cs);
    @(negedge clk);
    req_kind = k; req_pc = pc; req_in_delay = dly; status_in = st; cause_in = cs;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 reset valid", {31'b0, resp_valid}, 32'd0);
    chk("R1 reset ready", {31'b0, req_ready}, 32'd1);
  endtask

  task automatic t_syscall;
    send(5'd8, 32'h8000_1000, 1'b0, 5'b00000, 32'h0000_FF00);
    chk("R1 ack", {31'b0, resp_valid}, 32'd1);
    chk("R5 R6 pc", resp_pc, 32'h8000_0180);
    chk("R3 epc", resp_ret_pc, 32'h8000_1000);
    chk("R3 epc_we", {31'b0, resp_epc_we}, 32'd1);
    chk("R2 cause", resp_cause, 32'h0000_FF20);
    chk("R3 status", {27'b0, resp_status}, 32'h1);
  endtask

  task automatic t_delay;
    send(5'd9, 32'h8000_2004, 1'b1, 5'b00000, 32'h0);
    chk("R3 delay epc", resp_ret_pc, 32'h8000_2000);
    chk("R3 delay bd", resp_cause, 32'h8000_0024);
  endtask

  task automatic t_exl_set;
    send(5'd12, 32'h8000_3000, 1'b0, 5'b00001, 32'h8000_FF00);
    chk("R4 no epc", {31'b0, resp_epc_we}, 32'd0);
    chk("R4 bd kept", resp_cause, 32'h8000_FF30);
    chk("R4 status", {27'b0, resp_status}, 32'h1);
  endtask

  task automatic t_bev_and_base;
    send(5'd10, 32'h8000_0000, 1'b0, 5'b00100, 32'h0);
    chk("R5 bev pc", resp_pc, 32'hBFC0_0380);
    @(negedge clk); ebase = 32'h8000_0ABC;
    send(5'd10, 32'h8000_0000, 1'b0, 5'b00000, 32'h0);
    chk("R5 base low bits", resp_pc, 32'h8000_0980);
    @(negedge clk); ebase = 32'h8000_0000;
  endtask

  task automatic t_interrupt;
    send(5'd0, 32'h8000_0100, 1'b0, 5'b00000, 32'h0080_0000);
    chk("R6 iv pc", resp_pc, 32'h8000_0200);
    send(5'd0, 32'h8000_0100, 1'b0, 5'b00000, 32'h0);
    chk("R6 no iv pc", resp_pc, 32'h8000_0180);
  endtask

  task automatic t_refill;
    @(negedge clk); req_refill = 1'b1;
    send(5'd2, 32'h0040_0000, 1'b0, 5'b00000, 32'h0);
    chk("R7 refill pc", resp_pc, 32'h8000_0000);
    send(5'd3, 32'h0040_0000, 1'b0, 5'b00001, 32'h0);
    chk("R7 refill exl pc", resp_pc, 32'h8000_0180);
    @(negedge clk); req_refill = 1'b0;
  endtask

  task automatic t_cpu;
    @(negedge clk); req_cop = 2'd2;
    send(5'd11, 32'h8000_0400, 1'b0, 5'b00000, 32'h0);
    chk("R8 ce", resp_cause, 32'h2000_002C);
    @(negedge clk); req_cop = 2'd0;
  endtask

  task automatic t_cache;
    send(5'd30, 32'h8000_0500, 1'b0, 5'b00100, 32'h0);
    chk("R9 cache bev", resp_pc, 32'hBFC0_0100);
    send(5'd30, 32'h8000_0500, 1'b0, 5'b00000, 32'h0);
    chk("R9 cache reloc", resp_pc, 32'hA000_0100);
  endtask

  task automatic t_errlvl;
    send(5'd20, 32'h8000_3008, 1'b1, 5'b00000, 32'h0000_1234);
    chk("R10 nmi pc", resp_pc, 32'hBFC0_0000);
    chk("R10 nmi ret", resp_ret_pc, 32'h8000_3004);
    chk("R10 nmi we", {30'b0, resp_errepc_we, resp_epc_we}, 32'h2);
    chk("R10 nmi status", {27'b0, resp_status}, 32'h16);
    chk("R10 nmi cause", resp_cause, 32'h0000_1234);
    send(5'd21, 32'h8000_4000, 1'b0, 5'b00000, 32'h0);
    chk("R10 srst status", {27'b0, resp_status}, 32'h0E);
    chk("R10 srst ret", resp_ret_pc, 32'h8000_4000);
  endtask

  task automatic t_bad;
    send(5'd14, 32'h8000_5000, 1'b0, 5'b00101, 32'hABCD_0000);
    chk("R11 err", {31'b0, resp_err}, 32'd1);
    chk("R11 no we", {30'b0, resp_errepc_we, resp_epc_we}, 32'd0);
    chk("R11 cause", resp_cause, 32'hABCD_0000);
    chk("R11 status", {27'b0, resp_status}, 32'h05);
    chk("R11 pc", resp_pc, 32'h8000_5000);
  endtask

  task automatic t_stall;
    @(negedge clk); resp_ready = 1'b0;
    send(5'd8, 32'h8000_6000, 1'b0, 5'b00000, 32'h0);
    chk("R1 stall ready", {31'b0, req_ready}, 32'd0);
    send(5'd9, 32'h8000_7000, 1'b0, 5'b00000, 32'h0);
    chk("R1 stall hold", resp_ret_pc, 32'h8000_6000);
    chk("R1 stall valid", {31'b0, resp_valid}, 32'd1);
    resp_ready = 1'b1;
    @(negedge clk);
    chk("R1 drained", {31'b0, resp_valid}, 32'd0);
  endtask

  initial begin
    fork
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    join_none
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_syscall();
    t_delay();
    t_exl_set();
    t_bev_and_base();
    t_interrupt();
    t_refill();
    t_cpu();
    t_cache();
    t_errlvl();
    t_bad();
    t_stall();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule